// File: doc/BRIEF.md
# Event-Triggered Byte Mover with Terminator Stop

This block is one transfer channel that copies bytes from a source window into a destination buffer whose address climbs by one for every byte. It does nothing until the channel is switched on and one chosen hardware event line pulses. Each accepted pulse moves one cell, a programmed number of bytes. The typical use is draining a serial receiver. The source window is one byte long, so every read hits the same receive data register, and the cell is one byte, so every "byte ready" event moves exactly one character.

The channel can stop on content as well as on a count. When the compare option is on, every byte that is written is also checked against a stored terminator value. The byte that matches is still written, and the block then finishes. Software can therefore capture a message of unknown length that ends in a known delimiter, with the destination size acting only as an upper bound. When a block finishes, the channel switches itself off, raises a completion flag and rewinds its pointers. An access outside the legal address window aborts the channel and raises an error flag. Flags, together with per-flag enables, drive one interrupt line.

The register map has eight word offsets, selected by `regAddr`:
- 0: control. Bits [1:0] hold the priority, which is stored and read back only. Bit 7 switches the channel on.
- 1: event configuration. Bits [5:0] select the event line. Bit 8 enables the terminator compare.
- 2: terminator value, in bits [7:0].
- 3: source base address.
- 4: destination base address.
- 5: sizes. Bits [7:0] are the source size, [15:8] the destination size and [23:16] the cell size. A size of 0 means 256.
- 6: interrupt register. A read returns flags in bits [7:0] and enables in bits [23:16]. A write sets the bits written as 1.
- 7: interrupt clear. A write clears the flag and enable bits written as 1. A read returns the same value as offset 6.

Top module: `pm_dma_chan`

## Requirements
- R1: After reset, every register offset reads 0, `irq` is low and neither `memRe` nor `memWe` is asserted.
- R2: Control bits [1:0] store the priority and read back unchanged. Bit 7 switches the channel on. While bit 7 is 0, event pulses cause no memory access.
- R3: Only the event line whose index is held in event-configuration bits [5:0] starts a cell. Pulses on any other line cause no memory access.
- R4: Each accepted event moves one cell of bytes, the cell size (0 means 256). For every byte, the source is read with `memRe`, and in the next cycle the read data is written to the destination with `memWe`.
- R5: The source address is the source base plus a pointer. The pointer wraps to 0 after reaching the source size (0 means 256), so a source size of 1 reads one fixed address for every byte.
- R6: Destination byte i of a block goes to the destination base plus i. The block ends once destination-size bytes have been written (0 means 256), even in the middle of a cell.
- R7: When event-configuration bit 8 is 1, a written byte equal to terminator bits [7:0] is stored and then ends the block.
- R8: At block end, control bit 7 clears, flag bit 3 (block complete) sets, and both pointers rewind, so the next block starts again at the two base addresses.
- R9: Flag bit 2 (cell done) sets when a cell finishes without ending the block.
- R10: The legal address window runs from ADDR_LO to ADDR_HI. A source or destination address outside it sets flag bit 0 (address error), clears control bit 7, and suppresses that access and every later write.
- R11: `irq` is the OR over bits of flags [7:0] ANDed with enables [23:16]. Writes to offset 6 set bits and writes to offset 7 clear bits, leaving all other bits unchanged. `irq` stays high until the flag is cleared.
- R12: An accepted event that arrives while a cell is running is held as one pending request and starts the next cell once the current one finishes. Any further events before then are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 3 | Register word offset |
| regWe | input | 1 | Register write strobe |
| regWData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` |
| evIn | input | NUM_EV | Start event lines, one per event number |
| memAddr | output | ADDR_W | Memory byte address |
| memRe | output | 1 | Memory read strobe; data is returned in the next cycle |
| memWe | output | 1 | Memory write strobe |
| memWData | output | 8 | Memory write data |
| memRData | input | 8 | Memory read data |
| irq | output | 1 | Interrupt request |

## Verification
A source pointer that wraps at the wrong point shows up at once as a repeated or skipped byte in the destination buffer. A destination count or compare fault instead changes how long the captured message is, and whether the on bit and the block-complete flag read back correctly right after the last byte. Pending-request faults can be seen only as a total byte count that is wrong by a whole cell, one cell time after the burst of events. Address-window faults show within two cycles, as a write to a forbidden byte or a missing error flag.

// File: rtl/pm_dma_pkg.sv
package pm_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE
  } chState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic rd;
    logic wr;
    logic step;
    logic cellEnd;
    logic blockEnd;
    logic abort;
  } dmaStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic chOn;
    logic evHit;
    logic srcBad;
    logic dstBad;
    logic lastCell;
    logic lastByte;
    logic matchHit;
  } dmaStatus_t;

  localparam int FLG_ADDR_ERR = 0;
  localparam int FLG_CELL     = 2;
  localparam int FLG_BLOCK    = 3;

  localparam logic [2:0] OFS_CTRL  = 3'd0;
  localparam logic [2:0] OFS_EVCFG = 3'd1;
  localparam logic [2:0] OFS_MATCH = 3'd2;
  localparam logic [2:0] OFS_SRC   = 3'd3;
  localparam logic [2:0] OFS_DST   = 3'd4;
  localparam logic [2:0] OFS_SIZE  = 3'd5;
  localparam logic [2:0] OFS_ISET  = 3'd6;
  localparam logic [2:0] OFS_ICLR  = 3'd7;

endpackage

// File: rtl/pm_dma_ctrl.sv
module pm_dma_ctrl
  import pm_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dmaStatus_t stat,
  output dmaStrobe_t strobe
);

  chState_e state, stateNxt;
  logic     pend;
  logic     go;

  assign go = stat.chOn && (stat.evHit || pend);

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    case (state)
      ST_IDLE: begin
        if (go) stateNxt = ST_READ;
      end
      ST_READ: begin
        if (!stat.chOn) begin
          stateNxt = ST_IDLE;
        end else if (stat.srcBad) begin
          strobe.abort = 1'b1;
          stateNxt     = ST_IDLE;
        end else begin
          strobe.rd = 1'b1;
          stateNxt  = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (stat.dstBad) begin
          strobe.abort = 1'b1;
          stateNxt     = ST_IDLE;
        end else begin
          strobe.wr   = 1'b1;
          strobe.step = 1'b1;
          if (stat.matchHit || stat.lastByte) begin
            strobe.blockEnd = 1'b1;
            stateNxt        = ST_IDLE;
          end else if (stat.lastCell) begin
            strobe.cellEnd = 1'b1;
            stateNxt       = ST_IDLE;
          end else begin
            stateNxt = ST_READ;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      pend  <= 1'b0;
    end else begin
      state <= stateNxt;
      if (strobe.blockEnd || strobe.abort || !stat.chOn) begin
        pend <= 1'b0;
      end else if (state == ST_IDLE) begin
        if (go) pend <= 1'b0;
      end else if (stat.evHit) begin
        pend <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pm_dma_dpath.sv
module pm_dma_dpath
  import pm_dma_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int NUM_EV  = 64,
  parameter int SIZE_W  = 8,
  parameter int ADDR_LO = 16,
  parameter int ADDR_HI = 3839
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          regAddr,
  input  logic                regWe,
  input  logic [31:0]         regWData,
  output logic [31:0]         regRdData,
  input  logic [NUM_EV-1:0]   evIn,
  input  dmaStrobe_t          strobe,
  output dmaStatus_t          stat,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [7:0]          memWData,
  input  logic [7:0]          memRData,
  output logic                chOn,
  output logic [7:0]          intFlags,
  output logic [7:0]          intEn,
  output logic                irq
);

  localparam int CNT_W   = SIZE_W + 1;
  localparam int EVSEL_W = (NUM_EV > 1) ? $clog2(NUM_EV) : 1;
  localparam int AW1     = ADDR_W + 1;

  logic [1:0]          prio;
  logic [EVSEL_W-1:0]  evSel;
  logic                patEn;
  logic [7:0]          matchVal;
  logic [ADDR_W-1:0]   srcBase, dstBase;
  logic [SIZE_W-1:0]   srcSize, dstSize, cellSize;
  logic [CNT_W-1:0]    srcPtr, dstPtr, cellCnt;
  logic [CNT_W-1:0]    srcEff, dstEff, cellEff;
  logic [AW1-1:0]      srcSum, dstSum;
  logic                unusedBits;

  function automatic logic [CNT_W-1:0] effSize(input logic [SIZE_W-1:0] f);
    return (f == '0) ? CNT_W'(1 << SIZE_W) : CNT_W'(f);
  endfunction

  assign srcEff  = effSize(srcSize);
  assign dstEff  = effSize(dstSize);
  assign cellEff = effSize(cellSize);

  assign srcSum = {1'b0, srcBase} + AW1'(srcPtr);
  assign dstSum = {1'b0, dstBase} + AW1'(dstPtr);

  assign stat.chOn     = chOn;
  assign stat.evHit    = chOn && evIn[evSel];
  assign stat.srcBad   = (srcSum < AW1'(ADDR_LO)) || (srcSum > AW1'(ADDR_HI));
  assign stat.dstBad   = (dstSum < AW1'(ADDR_LO)) || (dstSum > AW1'(ADDR_HI));
  assign stat.lastCell = (cellCnt == cellEff - 1'b1);
  assign stat.lastByte = (dstPtr == dstEff - 1'b1);
  assign stat.matchHit = patEn && (memRData == matchVal);

  assign memAddr  = strobe.rd ? srcSum[ADDR_W-1:0] : dstSum[ADDR_W-1:0];
  assign memWData = memRData;
  assign irq      = |(intFlags & intEn);

  assign unusedBits = ^regWData[31:24];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prio     <= '0;
      chOn     <= 1'b0;
      evSel    <= '0;
      patEn    <= 1'b0;
      matchVal <= '0;
      srcBase  <= '0;
      dstBase  <= '0;
      srcSize  <= '0;
      dstSize  <= '0;
      cellSize <= '0;
      intFlags <= '0;
      intEn    <= '0;
      srcPtr   <= '0;
      dstPtr   <= '0;
      cellCnt  <= '0;
    end else begin
      if (regWe) begin
        case (regAddr)
          OFS_CTRL: begin
            prio <= regWData[1:0];
            chOn <= regWData[7];
          end
          OFS_EVCFG: begin
            evSel <= regWData[EVSEL_W-1:0];
            patEn <= regWData[8];
          end
          OFS_MATCH: matchVal <= regWData[7:0];
          OFS_SRC:   srcBase  <= regWData[ADDR_W-1:0];
          OFS_DST:   dstBase  <= regWData[ADDR_W-1:0];
          OFS_SIZE: begin
            srcSize  <= regWData[SIZE_W-1:0];
            dstSize  <= regWData[8+SIZE_W-1:8];
            cellSize <= regWData[16+SIZE_W-1:16];
          end
          OFS_ISET: begin
            intFlags <= intFlags | regWData[7:0];
            intEn    <= intEn | regWData[23:16];
          end
          OFS_ICLR: begin
            intFlags <= intFlags & ~regWData[7:0];
            intEn    <= intEn & ~regWData[23:16];
          end
          default: ;
        endcase
      end
      if (strobe.step) begin
        srcPtr  <= (srcPtr == srcEff - 1'b1) ? '0 : srcPtr + 1'b1;
        dstPtr  <= dstPtr + 1'b1;
        cellCnt <= cellCnt + 1'b1;
      end
      if (strobe.cellEnd) begin
        cellCnt              <= '0;
        intFlags[FLG_CELL]   <= 1'b1;
      end
      if (strobe.blockEnd || strobe.abort) begin
        chOn    <= 1'b0;
        srcPtr  <= '0;
        dstPtr  <= '0;
        cellCnt <= '0;
      end
      if (strobe.blockEnd) intFlags[FLG_BLOCK]    <= 1'b1;
      if (strobe.abort)    intFlags[FLG_ADDR_ERR] <= 1'b1;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      OFS_CTRL:  regRdData = {24'd0, chOn, 5'd0, prio};
      OFS_EVCFG: regRdData = {23'd0, patEn, 8'(evSel)};
      OFS_MATCH: regRdData = {24'd0, matchVal};
      OFS_SRC:   regRdData = 32'(srcBase);
      OFS_DST:   regRdData = 32'(dstBase);
      OFS_SIZE:  regRdData = {8'd0, 8'(cellSize), 8'(dstSize), 8'(srcSize)};
      default:   regRdData = {8'd0, intEn, 8'd0, intFlags};
    endcase
  end

endmodule

// File: rtl/pm_dma_chan.sv
module pm_dma_chan
  import pm_dma_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int NUM_EV  = 64,
  parameter int SIZE_W  = 8,
  parameter int ADDR_LO = 16,
  parameter int ADDR_HI = 3839
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWData,
  output logic [31:0]       regRdData,
  input  logic [NUM_EV-1:0] evIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [7:0]        memWData,
  input  logic [7:0]        memRData,
  output logic              irq
);

  dmaStrobe_t strobe;
  dmaStatus_t stat;
  logic       chOn;
  logic [7:0] intFlags;
  logic [7:0] intEn;

  assign memRe = strobe.rd;
  assign memWe = strobe.wr;

  pm_dma_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .stat   (stat),
    .strobe (strobe)
  );

  pm_dma_dpath #(
    .ADDR_W (ADDR_W),
    .NUM_EV (NUM_EV),
    .SIZE_W (SIZE_W),
    .ADDR_LO(ADDR_LO),
    .ADDR_HI(ADDR_HI)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWe    (regWe),
    .regWData (regWData),
    .regRdData(regRdData),
    .evIn     (evIn),
    .strobe   (strobe),
    .stat     (stat),
    .memAddr  (memAddr),
    .memWData (memWData),
    .memRData (memRData),
    .chOn     (chOn),
    .intFlags (intFlags),
    .intEn    (intEn),
    .irq      (irq)
  );

endmodule

// File: rtl/pm_dma_chan_chk.sv
module pm_dma_chan_chk #(
  parameter int ADDR_W  = 12,
  parameter int ADDR_LO = 16,
  parameter int ADDR_HI = 3839
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        regAddr,
  input logic              regWe,
  input logic              memRe,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              irq,
  input logic              chOn,
  input logic [7:0]        intFlags
);

  // R10: no write reaches a byte outside the legal window
  a_r10_write_in_window: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> ((int'(memAddr) >= ADDR_LO) && (int'(memAddr) <= ADDR_HI)));

  // R4: every write follows a read one cycle earlier
  a_r4_write_after_read: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> $past(memRe));

  // R4: read and write never share a cycle
  a_r4_one_access: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe));

  // R2: no read while the channel is off
  a_r2_read_needs_on: assert property (@(posedge clk) disable iff (!rstN)
    memRe |-> chOn);

  // R8: block-complete flag rises together with the on bit dropping
  a_r8_done_turns_off: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intFlags[3]) |-> !chOn);

  // R11: interrupt holds until a clear write
  a_r11_irq_held: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(regWe && regAddr == 3'd7)) |=> irq);

endmodule

bind pm_dma_chan pm_dma_chan_chk #(
  .ADDR_W (ADDR_W),
  .ADDR_LO(ADDR_LO),
  .ADDR_HI(ADDR_HI)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .regAddr (regAddr),
  .regWe   (regWe),
  .memRe   (memRe),
  .memWe   (memWe),
  .memAddr (memAddr),
  .irq     (irq),
  .chOn    (chOn),
  .intFlags(intFlags)
);

// File: tb/pm_dma_chan_test.sv
module pm_dma_chan_test;

  localparam int ADDR_W = 12;
  localparam int NUM_EV = 64;
  localparam int EV_RX  = 27;
  localparam int SRC    = 'h100;
  localparam int DST    = 'h200;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [2:0]        regAddr = '0;
  logic              regWe = 1'b0;
  logic [31:0]       regWData = '0;
  logic [31:0]       regRdData;
  logic [NUM_EV-1:0] evIn = '0;
  logic [ADDR_W-1:0] memAddr;
  logic              memRe, memWe;
  logic [7:0]        memWData;
  logic [7:0]        memRData = '0;
  logic              irq;

  logic [7:0] mem [0:(1<<ADDR_W)-1];
  int checks = 0;
  int errors = 0;
  int wrCount = 0;

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) begin
    if (memRe) memRData <= mem[memAddr];
    if (memWe) begin
      mem[memAddr] <= memWData;
      wrCount <= wrCount + 1;
    end
  end

  pm_dma_chan uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWData(regWData), .regRdData(regRdData), .evIn(evIn),
    .memAddr(memAddr), .memRe(memRe), .memWe(memWe),
    .memWData(memWData), .memRData(memRData), .irq(irq)
  );

  // rows: srcSz, dstSz, cellSz, patEn, match, trigs, expCount, expDone
  localparam logic [63:0] VEC [6] = '{
    64'h10_08_01_00_00_08_08_01,
    64'h10_0A_04_00_00_02_08_00,
    64'h10_0A_04_00_00_03_0A_01,
    64'h10_00_03_01_45_03_05_01,
    64'h02_06_06_00_00_01_06_01,
    64'h10_00_02_01_7F_02_04_00
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWData = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    evIn[idx] = 1'b1;
    @(negedge clk);
    evIn[idx] = 1'b0;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    waitN(2);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int base;
    for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = 8'hEE;
    for (int i = 0; i < 64; i++) mem[SRC+i] = 8'(8'h41 + i);
    waitN(3);
    rstN = 1'b1;

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), r);
      chk("R1 reg reset", int'(r), 0);
    end
    chk("R1 irq reset", int'(irq), 0);
    chk("R1 no access", int'(memRe | memWe), 0);

    // table walk: R4 R5 R6 R7 R8 R9
    for (int v = 0; v < 6; v++) begin
      int srcSz, cellSz, trigs, expCnt, expDone;
      logic [63:0] row;
      row = VEC[v];
      srcSz  = int'(row[63:56]);
      cellSz = (row[47:40] == 0) ? 256 : int'(row[47:40]);
      trigs  = int'(row[23:16]);
      expCnt = int'(row[15:8]);
      expDone = int'(row[7:0]);
      doReset();
      for (int i = 0; i < 256; i++) mem[DST+i] = 8'hEE;
      wr(3'd3, SRC);
      wr(3'd4, DST);
      wr(3'd5, {8'd0, row[47:40], row[55:48], row[63:56]});
      wr(3'd2, {24'd0, row[31:24]});
      wr(3'd1, {23'd0, row[32], 8'(EV_RX)});
      wr(3'd0, 32'h80);
      base = wrCount;
      for (int t = 0; t < trigs; t++) begin
        pulse(EV_RX);
        waitN(2 * cellSz + 6);
      end
      chk("R4 R6 R7 byte count", wrCount - base, expCnt);
      for (int i = 0; i < expCnt; i++)
        chk("R5 R6 dst content", int'(mem[DST+i]), int'(8'(8'h41 + (i % srcSz))));
      chk("R6 R7 no extra byte", int'(mem[DST+expCnt]), 'hEE);
      rd(3'd6, r);
      chk("R8 block flag", int'(r[3]), expDone);
      chk("R9 cell flag", int'(r[2]), (expDone == 0) ? 1 : int'(expCnt > cellSz));
      rd(3'd0, r);
      chk("R8 on bit", int'(r[7]), 1 - expDone);
    end

    // R2: priority readback, events ignored while off
    doReset();
    wr(3'd0, 32'h3);
    rd(3'd0, r);
    chk("R2 priority readback", int'(r), 3);
    wr(3'd3, SRC); wr(3'd4, DST); wr(3'd5, 32'h0001_0010);
    wr(3'd1, EV_RX);
    base = wrCount;
    pulse(EV_RX); waitN(6);
    chk("R2 off ignores event", wrCount - base, 0);

    // R3: other event ignored, selected one served
    wr(3'd0, 32'h80);
    base = wrCount;
    pulse(5); waitN(6);
    chk("R3 other event ignored", wrCount - base, 0);
    pulse(EV_RX); waitN(6);
    chk("R3 selected event", wrCount - base, 1);

    // R7 R5: fixed source, terminator capture; R8 pointer rewind
    doReset();
    for (int i = 0; i < 8; i++) mem['h400+i] = 8'hEE;
    wr(3'd3, 'h300); wr(3'd4, 'h400); wr(3'd5, 32'h0001_0001);
    wr(3'd2, 32'h0D); wr(3'd1, 32'h100 | EV_RX); wr(3'd0, 32'h80);
    mem['h300] = 8'h4F; pulse(EV_RX); waitN(6);
    mem['h300] = 8'h4B; pulse(EV_RX); waitN(6);
    mem['h300] = 8'h0D; pulse(EV_RX); waitN(6);
    chk("R5 fixed src byte0", int'(mem['h400]), 'h4F);
    chk("R5 fixed src byte1", int'(mem['h401]), 'h4B);
    chk("R7 terminator stored", int'(mem['h402]), 'h0D);
    rd(3'd0, r);
    chk("R7 R8 on cleared", int'(r[7]), 0);
    wr(3'd0, 32'h80);
    mem['h300] = 8'h5A; pulse(EV_RX); waitN(6);
    chk("R8 rewind to base", int'(mem['h400]), 'h5A);
    chk("R8 no write past", int'(mem['h403]), 'hEE);

    // R10: destination runs out of window
    doReset();
    mem['hF00] = 8'hEE;
    wr(3'd3, SRC); wr(3'd4, 'hEFE); wr(3'd5, 32'h0004_0810);
    wr(3'd1, EV_RX); wr(3'd0, 32'h80);
    base = wrCount;
    pulse(EV_RX); waitN(14);
    chk("R10 writes before error", wrCount - base, 2);
    chk("R10 forbidden byte untouched", int'(mem['hF00]), 'hEE);
    rd(3'd6, r);
    chk("R10 error flag", int'(r[0]), 1);
    rd(3'd0, r);
    chk("R10 on cleared", int'(r[7]), 0);

    // R11: interrupt set/clear
    doReset();
    wr(3'd6, 32'h0008_0000);
    wr(3'd3, SRC); wr(3'd4, DST); wr(3'd5, 32'h0001_0110);
    wr(3'd1, EV_RX); wr(3'd0, 32'h80);
    chk("R11 irq low before", int'(irq), 0);
    pulse(EV_RX); waitN(6);
    chk("R11 irq on block", int'(irq), 1);
    waitN(5);
    chk("R11 irq held", int'(irq), 1);
    wr(3'd7, 32'h8);
    #1;
    chk("R11 irq cleared", int'(irq), 0);
    rd(3'd6, r);
    chk("R11 enable kept", int'(r), 'h0008_0000);

    // R12: burst of events during a cell, one held
    doReset();
    wr(3'd3, SRC); wr(3'd4, DST); wr(3'd5, 32'h0004_0010);
    wr(3'd1, EV_RX); wr(3'd0, 32'h80);
    base = wrCount;
    pulse(EV_RX); pulse(EV_RX); pulse(EV_RX);
    waitN(30);
    chk("R12 one pending kept", wrCount - base, 8);
    rd(3'd6, r);
    chk("R12 R9 cell flag only", int'(r[3:0]), 4);

    // R6: size 0 means 256
    doReset();
    for (int i = 0; i < 256; i++) mem[SRC+i] = 8'(i ^ 'h5A);
    wr(3'd3, SRC); wr(3'd4, 'h600); wr(3'd5, 32'h0);
    wr(3'd1, EV_RX); wr(3'd0, 32'h80);
    base = wrCount;
    pulse(EV_RX); waitN(530);
    chk("R6 full 256 bytes", wrCount - base, 256);
    chk("R6 last byte", int'(mem['h6FF]), 'hFF ^ 'h5A);
    rd(3'd6, r);
    chk("R6 block flag at 256", int'(r[3]), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule